// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits next to a small processor core. It gathers interrupt requests and keeps a registered mask of pending vectors. When the core reaches an instruction boundary and strobes "take", the block picks one vector and reports its index and the 16-bit address of its vector-table entry. It also says which condition-code mask bit the core must set. Peripheral requests come from pairs of status flags and enable bits. Several flags may share one vector. One source has no enable and requests on its flag alone. The core itself raises three events: a software trap, an illegal-opcode trap and a non-maskable request.

Selection works in fixed classes. Software trap and illegal opcode come first, in that order, and ignore both mask bits. The non-maskable request comes next and is gated only by the X bit. Every peripheral vector is gated by the I bit and chosen through a reprogrammable priority table, which holds the identity order after reset. Event requests are dropped when they are accepted. Peripheral requests follow their flags and so come back after return if the handler left the flag set. After each acceptance the block refuses further strobes for a fixed busy interval that stands for the cost of stacking.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A peripheral source requests when its flag and its enable are both 1. Source 11 has no enable and requests whenever its flag is 1. A flag with its enable at 0 (sources 0..10) causes no acceptance. Sources 0..3 map to vector 0, and source s (4..11) maps to vector s-3.
- R2: A shared vector stays pending while any one of its contributing flags is active. It drops only when all of them are inactive. The mask is re-evaluated on every clock, clearing before setting.
- R3: The software trap (vector 10) is selected before the illegal-opcode trap (vector 11), and both are selected before everything else, whatever the I and X bits are. Each pending event bit clears when that vector is accepted.
- R4: The non-maskable request (vector 9) is selected after the two traps, but only when X is 0. Its pending bit clears when it is accepted. While X is 1 it stays pending.
- R5: While I is 1, no peripheral vector is accepted.
- R6: Peripheral vectors are chosen by the first matching slot of the priority table. After reset, slot k holds vector k, so the lowest pending index wins. A write to a slot changes the order.
- R7: Accepting a peripheral vector does not clear it. A second strobe accepts it again while its flag stays set.
- R8: The vector address is the base plus twice the index. The base is 0xFFC0 when the boot strap is 0 and 0xBFC0 when it is 1.
- R9: Every acceptance of vector 9 raises set_x_o and not set_i_o. Every other acceptance raises set_i_o and not set_x_o. Both are low when nothing is accepted.
- R10: After an acceptance, strobes on the next 14 clocks are ignored. The next acceptance can occur 15 clocks after the previous one.
- R11: acc_valid_o is high for exactly one clock, after a strobe that found an eligible vector. A strobe with nothing eligible leaves it low.
- R12: After reset, the pending mask is empty and acc_valid_o, set_i_o and set_x_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flag_i | input | NUM_SRC | Peripheral status flags |
| en_i | input | NUM_SRC | Peripheral enable bits |
| swi_i | input | 1 | Software trap event pulse |
| ill_i | input | 1 | Illegal-opcode event pulse |
| nmi_i | input | 1 | Non-maskable request pulse |
| ccr_i_i | input | 1 | Condition-code I mask bit |
| ccr_x_i | input | 1 | Condition-code X mask bit |
| boot_i | input | 1 | Special/boot mode strap |
| take_i | input | 1 | Take-interrupt strobe from the instruction boundary |
| ord_we_i | input | 1 | Priority table write enable |
| ord_slot_i | input | IW | Priority slot written |
| ord_idx_i | input | IW | Vector index stored in that slot |
| acc_valid_o | output | 1 | One-clock acceptance pulse |
| acc_idx_o | output | IW | Accepted vector index |
| acc_addr_o | output | 16 | Vector-table address of the accepted vector |
| set_i_o | output | 1 | Request to set I |
| set_x_o | output | 1 | Request to set X |

## Verification
The bench uses the defaults: twelve sources with four shared onto vector 0, source 11 without an enable, and a busy interval of 14. That gives twelve vectors, with the non-maskable request at 9 and the traps at 10 and 11. The shared vector can be tested by dropping its flags one at a time. Every selection class can be pending at once. The priority table is small enough to swap two slots and see the winner change. The 14-clock busy window is short enough to measure exactly with a strobe held high.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam logic [15:0] BASE_NORMAL = 16'hFFC0;
  localparam logic [15:0] BASE_BOOT   = 16'hBFC0;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_TRAP  = 2'd1,
    CLS_NMI   = 2'd2,
    CLS_MASK  = 2'd3
  } sel_class_e;

  // Which vector a peripheral source feeds: a group of shared sources
  // lands on vector 0, the rest take consecutive vectors after it.
  function automatic int src_to_vec(input int src, input int shared);
    return (src < shared) ? 0 : src - shared + 1;
  endfunction

  // Table entry address: base plus two bytes per vector.
  function automatic logic [15:0] vec_addr(input logic boot, input logic [7:0] idx);
    logic [15:0] base;
    base = boot ? BASE_BOOT : BASE_NORMAL;
    return base + {7'd0, idx, 1'b0};
  endfunction
endpackage

// File: rtl/ivc_pending.sv
module ivc_pending
  import ivc_pkg::*;
#(
  parameter int NUM_SRC   = 12,
  parameter int SHARED    = 4,
  parameter logic [NUM_SRC-1:0] NOEN_MASK = '0,
  parameter int PV        = NUM_SRC - SHARED + 1,
  parameter int NUM_VEC   = PV + 3,
  parameter int IW        = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] flag_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic               swi_i,
  input  logic               ill_i,
  input  logic               nmi_i,
  input  logic               clr_en_i,
  input  logic [IW-1:0]      clr_idx_i,
  output logic [NUM_VEC-1:0] pend_o
);
  localparam int NMI_IDX = PV;
  localparam int SWI_IDX = PV + 1;
  localparam int ILL_IDX = PV + 2;

  logic [NUM_SRC-1:0] src_act;
  logic [PV-1:0]      set_m;
  logic [PV-1:0]      clr_m;
  logic [NUM_VEC-1:0] pend_q;
  logic [NUM_VEC-1:0] pend_n;

  genvar gs;
  generate
    for (gs = 0; gs < NUM_SRC; gs++) begin : g_src
      if (NOEN_MASK[gs]) begin : g_noen
        assign src_act[gs] = flag_i[gs];
      end else begin : g_en
        assign src_act[gs] = flag_i[gs] & en_i[gs];
      end
    end
  endgenerate

  // Collect the requests of each peripheral vector from all its sources.
  always_comb begin
    set_m = '0;
    for (int v = 0; v < PV; v++) begin
      for (int s = 0; s < NUM_SRC; s++) begin
        if (src_to_vec(s, SHARED) == v) set_m[v] = set_m[v] | src_act[s];
      end
    end
    clr_m = ~set_m;
  end

  function automatic logic event_next(input logic cur, input logic pulse,
                                      input logic clr, input logic [IW-1:0] cidx,
                                      input int me);
    return pulse | (cur & ~(clr && (cidx == IW'(me))));
  endfunction

  always_comb begin
    pend_n = pend_q;
    pend_n[PV-1:0] = (pend_q[PV-1:0] & ~clr_m) | set_m;
    pend_n[NMI_IDX] = event_next(pend_q[NMI_IDX], nmi_i, clr_en_i, clr_idx_i, NMI_IDX);
    pend_n[SWI_IDX] = event_next(pend_q[SWI_IDX], swi_i, clr_en_i, clr_idx_i, SWI_IDX);
    pend_n[ILL_IDX] = event_next(pend_q[ILL_IDX], ill_i, clr_en_i, clr_idx_i, ILL_IDX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_n;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/ivc_order.sv
module ivc_order #(
  parameter int NUM_VEC = 12,
  parameter int IW      = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we_i,
  input  logic [IW-1:0]         slot_i,
  input  logic [IW-1:0]         idx_i,
  output logic [NUM_VEC*IW-1:0] ord_flat_o
);
  logic [IW-1:0] ord_q [NUM_VEC];

  genvar gk;
  generate
    for (gk = 0; gk < NUM_VEC; gk++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              ord_q[gk] <= IW'(gk);
        else if (we_i && (slot_i == IW'(gk)))    ord_q[gk] <= idx_i;
      end
      assign ord_flat_o[gk*IW +: IW] = ord_q[gk];
    end
  endgenerate
endmodule

// File: rtl/ivc_select.sv
module ivc_select
  import ivc_pkg::*;
#(
  parameter int PV      = 9,
  parameter int NUM_VEC = PV + 3,
  parameter int IW      = 4
) (
  input  logic [NUM_VEC-1:0]    pend_i,
  input  logic [NUM_VEC*IW-1:0] ord_flat_i,
  input  logic                  ccr_i_i,
  input  logic                  ccr_x_i,
  output logic                  sel_ok_o,
  output logic [IW-1:0]         sel_idx_o,
  output sel_class_e            sel_cls_o
);
  localparam int NMI_IDX = PV;
  localparam int SWI_IDX = PV + 1;
  localparam int ILL_IDX = PV + 2;

  logic          mask_hit;
  logic [IW-1:0] mask_idx;

  // Walk the table from the last slot down so the first slot wins.
  always_comb begin
    mask_hit = 1'b0;
    mask_idx = '0;
    for (int k = NUM_VEC - 1; k >= 0; k--) begin
      logic [IW-1:0] cand;
      cand = ord_flat_i[k*IW +: IW];
      if (int'(cand) < PV) begin
        if (pend_i[cand]) begin
          mask_hit = 1'b1;
          mask_idx = cand;
        end
      end
    end
  end

  always_comb begin
    sel_ok_o  = 1'b0;
    sel_idx_o = '0;
    sel_cls_o = CLS_NONE;
    if (pend_i[SWI_IDX]) begin
      sel_ok_o = 1'b1; sel_idx_o = IW'(SWI_IDX); sel_cls_o = CLS_TRAP;
    end else if (pend_i[ILL_IDX]) begin
      sel_ok_o = 1'b1; sel_idx_o = IW'(ILL_IDX); sel_cls_o = CLS_TRAP;
    end else if (pend_i[NMI_IDX] && !ccr_x_i) begin
      sel_ok_o = 1'b1; sel_idx_o = IW'(NMI_IDX); sel_cls_o = CLS_NMI;
    end else if (!ccr_i_i && mask_hit) begin
      sel_ok_o = 1'b1; sel_idx_o = mask_idx; sel_cls_o = CLS_MASK;
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
#(
  parameter int NUM_SRC  = 12,
  parameter int SHARED   = 4,
  parameter logic [NUM_SRC-1:0] NOEN_MASK = 12'h800,
  parameter int BUSY_CYC = 14,
  localparam int PV      = NUM_SRC - SHARED + 1,
  localparam int NUM_VEC = PV + 3,
  localparam int IW      = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] flag_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic               swi_i,
  input  logic               ill_i,
  input  logic               nmi_i,
  input  logic               ccr_i_i,
  input  logic               ccr_x_i,
  input  logic               boot_i,
  input  logic               take_i,
  input  logic               ord_we_i,
  input  logic [IW-1:0]      ord_slot_i,
  input  logic [IW-1:0]      ord_idx_i,
  output logic               acc_valid_o,
  output logic [IW-1:0]      acc_idx_o,
  output logic [15:0]        acc_addr_o,
  output logic               set_i_o,
  output logic               set_x_o
);
  localparam int CW = $clog2(BUSY_CYC + 1);

  logic [NUM_VEC-1:0]    pend;
  logic [NUM_VEC*IW-1:0] ord_flat;
  logic                  sel_ok;
  logic [IW-1:0]         sel_idx;
  sel_class_e            sel_cls;
  logic [CW-1:0]         busy_q;
  logic                  take_ok;
  logic                  accept;

  ivc_pending #(
    .NUM_SRC(NUM_SRC), .SHARED(SHARED), .NOEN_MASK(NOEN_MASK),
    .PV(PV), .NUM_VEC(NUM_VEC), .IW(IW)
  ) u_pend (
    .clk(clk), .rst_n(rst_n), .flag_i(flag_i), .en_i(en_i),
    .swi_i(swi_i), .ill_i(ill_i), .nmi_i(nmi_i),
    .clr_en_i(accept), .clr_idx_i(sel_idx), .pend_o(pend)
  );

  ivc_order #(.NUM_VEC(NUM_VEC), .IW(IW)) u_ord (
    .clk(clk), .rst_n(rst_n), .we_i(ord_we_i), .slot_i(ord_slot_i),
    .idx_i(ord_idx_i), .ord_flat_o(ord_flat)
  );

  ivc_select #(.PV(PV), .NUM_VEC(NUM_VEC), .IW(IW)) u_sel (
    .pend_i(pend), .ord_flat_i(ord_flat), .ccr_i_i(ccr_i_i), .ccr_x_i(ccr_x_i),
    .sel_ok_o(sel_ok), .sel_idx_o(sel_idx), .sel_cls_o(sel_cls)
  );

  assign take_ok = take_i && (busy_q == '0);
  assign accept  = take_ok && sel_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          busy_q <= '0;
    else if (accept)     busy_q <= CW'(BUSY_CYC);
    else if (busy_q != 0) busy_q <= busy_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_valid_o <= 1'b0;
      acc_idx_o   <= '0;
      acc_addr_o  <= '0;
      set_i_o     <= 1'b0;
      set_x_o     <= 1'b0;
    end else begin
      acc_valid_o <= accept;
      set_x_o     <= accept && (sel_cls == CLS_NMI);
      set_i_o     <= accept && (sel_cls != CLS_NMI);
      if (accept) begin
        acc_idx_o  <= sel_idx;
        acc_addr_o <= vec_addr(boot_i, 8'(sel_idx));
      end
    end
  end
endmodule

// File: rtl/ivc_checker.sv
module ivc_checker #(
  parameter int NUM_VEC  = 12,
  parameter int IW       = 4,
  parameter int BUSY_CYC = 14
) (
  input logic               clk,
  input logic               rst_n,
  input logic               take_i,
  input logic               ccr_i_i,
  input logic               ccr_x_i,
  input logic               boot_i,
  input logic               take_ok,
  input logic [NUM_VEC-1:0] pend,
  input logic               acc_valid_o,
  input logic [IW-1:0]      acc_idx_o,
  input logic [15:0]        acc_addr_o,
  input logic               set_i_o,
  input logic               set_x_o
);
  localparam int NMI_IDX = NUM_VEC - 3;
  localparam int SWI_IDX = NUM_VEC - 2;
  localparam int ILL_IDX = NUM_VEC - 1;

  logic [7:0] gap;
  logic       seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap <= '0; seen <= 1'b0;
    end else if (acc_valid_o) begin
      gap <= '0; seen <= 1'b1;
    end else if (gap != 8'hFF) begin
      gap <= gap + 1'b1;
    end
  end

  a_r9_one_mask: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid_o |-> $onehot({set_i_o, set_x_o}));
  a_r9_idle_mask: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid_o |-> !set_i_o && !set_x_o);
  a_r9_nmi_sets_x: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid_o && (acc_idx_o == IW'(NMI_IDX)) |-> set_x_o);
  a_r11_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid_o |=> !acc_valid_o);
  a_r11_needs_take: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_valid_o) |-> $past(take_i));
  a_r10_busy_gap: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid_o |-> !seen || (gap >= 8'(BUSY_CYC)));
  a_r3_trap_first: assert property (@(posedge clk) disable iff (!rst_n)
    take_ok && pend[SWI_IDX] |=> acc_valid_o && (acc_idx_o == IW'(SWI_IDX)));
  a_r5_i_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    take_ok && ccr_i_i && !pend[SWI_IDX] && !pend[ILL_IDX] &&
    !(pend[NMI_IDX] && !ccr_x_i) |=> !acc_valid_o);
  a_r8_base: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_valid_o) && $past(rst_n) |->
      acc_addr_o[15:8] == ($past(boot_i) ? 8'hBF : 8'hFF));
endmodule

bind irq_vector_ctrl ivc_checker #(.NUM_VEC(NUM_VEC), .IW(IW), .BUSY_CYC(BUSY_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .take_i(take_i), .ccr_i_i(ccr_i_i), .ccr_x_i(ccr_x_i),
  .boot_i(boot_i), .take_ok(take_ok), .pend(pend), .acc_valid_o(acc_valid_o),
  .acc_idx_o(acc_idx_o), .acc_addr_o(acc_addr_o), .set_i_o(set_i_o), .set_x_o(set_x_o)
);

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] flag_i = '0;
  logic [11:0] en_i = '0;
  logic        swi_i = 0, ill_i = 0, nmi_i = 0;
  logic        ccr_i_i = 0, ccr_x_i = 0, boot_i = 0, take_i = 0;
  logic        ord_we_i = 0;
  logic [3:0]  ord_slot_i = '0, ord_idx_i = '0;
  logic        acc_valid_o;
  logic [3:0]  acc_idx_o;
  logic [15:0] acc_addr_o;
  logic        set_i_o, set_x_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  irq_vector_ctrl uut (
    .clk(clk), .rst_n(rst_n), .flag_i(flag_i), .en_i(en_i),
    .swi_i(swi_i), .ill_i(ill_i), .nmi_i(nmi_i),
    .ccr_i_i(ccr_i_i), .ccr_x_i(ccr_x_i), .boot_i(boot_i), .take_i(take_i),
    .ord_we_i(ord_we_i), .ord_slot_i(ord_slot_i), .ord_idx_i(ord_idx_i),
    .acc_valid_o(acc_valid_o), .acc_idx_o(acc_idx_o), .acc_addr_o(acc_addr_o),
    .set_i_o(set_i_o), .set_x_o(set_x_o)
  );

  always #2 clk = ~clk;

  function automatic logic [15:0] exp_addr(input logic boot, input int idx);
    return (boot ? 16'hBFC0 : 16'hFFC0) + 16'(idx * 2);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Strobe once after the busy window has certainly expired; outputs are
  // sampled one negedge later, after the registering posedge.
  task automatic take_once();
    step(16);
    take_i = 1;
    @(negedge clk);
    take_i = 0;
  endtask

  task automatic expect_take(input string req, input int idx, input bit x);
    take_once();
    check(req, "valid", acc_valid_o, 1);
    check(req, "index", acc_idx_o, idx);
    check("R8", "address", acc_addr_o, exp_addr(boot_i, idx));
    check("R9", "set_x", set_x_o, x);
    check("R9", "set_i", set_i_o, !x);
  endtask

  task automatic expect_none(input string req);
    take_once();
    check(req, "no acceptance", acc_valid_o, 0);
    check("R9", "masks idle", {set_i_o, set_x_o}, 0);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: swi_i = 1;
      1: ill_i = 1;
      default: nmi_i = 1;
    endcase
    @(negedge clk);
    swi_i = 0; ill_i = 0; nmi_i = 0;
  endtask

  task automatic t_reset();
    step(1);
    check("R12", "valid after reset", acc_valid_o, 0);
    check("R12", "masks after reset", {set_i_o, set_x_o}, 0);
    expect_none("R12");
  endtask

  task automatic t_enable();
    flag_i[6] = 1;
    expect_none("R1");
    en_i[6] = 1;
    expect_take("R1", 3, 0);
    flag_i[6] = 0; en_i[6] = 0;
    flag_i[11] = 1;
    expect_take("R1", 8, 0);
    flag_i[11] = 0;
    step(2);
  endtask

  task automatic t_shared();
    en_i[3:0] = 4'hF;
    flag_i[0] = 1; flag_i[2] = 1;
    step(2);
    flag_i[0] = 0;
    expect_take("R2", 0, 0);
    flag_i[2] = 0;
    expect_none("R2");
    en_i[3:0] = 4'h0;
  endtask

  task automatic t_traps();
    ccr_i_i = 1; ccr_x_i = 1;
    flag_i[4] = 1; en_i[4] = 1;
    pulse(2); pulse(1); pulse(0);
    expect_take("R3", 10, 0);
    expect_take("R3", 11, 0);
    expect_none("R4");
    ccr_x_i = 0;
    expect_take("R4", 9, 1);
    expect_none("R4");
    flag_i[4] = 0; en_i[4] = 0;
    ccr_i_i = 0;
    step(2);
  endtask

  task automatic t_imask();
    flag_i[5] = 1; en_i[5] = 1;
    ccr_i_i = 1;
    expect_none("R5");
    ccr_i_i = 0;
    expect_take("R5", 2, 0);
    expect_take("R7", 2, 0);
    flag_i[5] = 0;
    expect_none("R7");
    en_i[5] = 0;
  endtask

  task automatic t_order();
    flag_i[4] = 1; en_i[4] = 1;
    flag_i[8] = 1; en_i[8] = 1;
    expect_take("R6", 1, 0);
    @(negedge clk);
    ord_we_i = 1; ord_slot_i = 4'd0; ord_idx_i = 4'd5;
    @(negedge clk);
    ord_slot_i = 4'd5; ord_idx_i = 4'd0;
    @(negedge clk);
    ord_we_i = 0;
    expect_take("R6", 5, 0);
    boot_i = 1;
    expect_take("R8", 5, 0);
    boot_i = 0;
    flag_i[8] = 0; en_i[8] = 0;
  endtask

  task automatic t_busy();
    int first, second, highs;
    first = -1; second = -1; highs = 0;
    step(16);
    take_i = 1;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (acc_valid_o) begin
        highs++;
        if (first < 0) first = c;
        else if (second < 0) second = c;
      end
    end
    take_i = 0;
    check("R10", "gap between acceptances", second - first, 15);
    check("R11", "pulses in 40 clocks", highs, 3);
    flag_i[4] = 0; en_i[4] = 0;
    step(16);
  endtask

  initial begin
    step(3);
    rst_n = 1;
    t_reset();
    t_enable();
    t_shared();
    t_traps();
    t_imask();
    t_order();
    t_busy();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=running expected=finished");
      end
    join_any
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule